// File: doc/BRIEF.md
# Split Safe/Unsafe Store Buffer

This block sits between a core's retire stage and its data cache. Stores retire into one of two buffers, chosen by a safety flag that the coherence layer attaches to each access. Stores to blocks that may be written by other threads are "unsafe". They go into a strict first-in first-out queue, and stores to the same address are never combined there. Stores to private or read-only blocks are "safe". They go into a small unordered buffer, where a later store to an address already held merges its enabled bytes into the existing slot.

The block also decides when a retiring load may leave. A safe load never waits. An unsafe load waits only until the ordered queue is empty; it does not wait for the safe buffer. An access whose safety status is not yet known is held back. Loads receive forwarded bytes from buffered stores to the same address. For each byte, the youngest ordered entry wins, and the safe slot is used when no ordered entry covers that byte.

A downgrade request moves the control FSM from `RUN` to `FLUSH` (transition "downgrade"). In `FLUSH`, new stores are held off and both buffers drain. When both are empty the FSM moves to `ACK` (transition "drained") and raises the acknowledgement for one cycle, then returns to `RUN` (transition "resume"). The drain port writes at most one entry per cycle.

Top module: `split_store_buffer`

## Requirements
- R1: After reset both buffers are empty: `dr_valid`, `dg_ack` and `st_stall` are 0 and all three counters are 0.
- R2: Unsafe stores drain in the order they were accepted. Two unsafe stores to the same address give two separate drain beats.
- R3: A safe store to an address already held in the safe buffer replaces only the bytes selected by its `st_be` (bit b covers data bits 8b+7..8b). The slot's byte mask becomes the OR of both masks. The slot drains as one beat.
- R4: When the ordered queue holds an entry, its head is offered on the drain port. Safe entries are offered only when the queue is empty, and then the lowest occupied slot goes first. Safe entries are never offered in a cycle that accepts a safe store. One entry is removed at each clock edge where `dr_valid` and `dr_ready` are both high.
- R5: A load with known status and `ld_safe`=1 gets `ld_retire`=1 in the same cycle, whatever the buffers hold.
- R6: A load with known status and `ld_safe`=0 gets `ld_retire`=1 exactly when the ordered queue is empty, even if the safe buffer holds entries.
- R7: While `st_known` is 0 no store is accepted. While `ld_known` is 0 `ld_retire` stays 0.
- R8: `ld_fwd_be`/`ld_fwd_data` give, for each byte, the value from the youngest matching ordered entry that enables that byte. Otherwise they give the value from the matching safe slot. Bytes not covered have a mask bit of 0 and data 0.
- R9: `st_stall` is 1 whenever either buffer is full, and no store is accepted while it is 1.
- R10: A `dg_req` pulse in `RUN` enters `FLUSH`, where `st_stall`=1. The FSM leaves `FLUSH` at the edge after the cycle in which both buffers are seen empty. `dg_ack` is then 1 for exactly one cycle, and the FSM returns to `RUN`.
- R11: At each edge where a load retires, `cnt_ld_fast` increments if the load was never refused, and `cnt_ld_wait` increments if an earlier cycle refused it. `cnt_merge` increments for each safe store that merges into an existing slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Retiring store present |
| st_known | input | 1 | Store safety status is known |
| st_safe | input | 1 | Store targets a safe block |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables |
| st_accept | output | 1 | Store taken this cycle |
| st_stall | output | 1 | Retire stage must hold stores |
| ld_valid | input | 1 | Retiring load present |
| ld_known | input | 1 | Load safety status is known |
| ld_safe | input | 1 | Load targets a safe block |
| ld_addr | input | AW | Load address |
| ld_retire | output | 1 | Load may leave this cycle |
| ld_fwd_be | output | DW/8 | Bytes supplied by forwarding |
| ld_fwd_data | output | DW | Forwarded bytes |
| dr_valid | output | 1 | Drain entry offered |
| dr_ready | input | 1 | Cache takes the drain entry |
| dr_addr | output | AW | Drain address |
| dr_data | output | DW | Drain data |
| dr_be | output | DW/8 | Drain byte enables |
| dg_req | input | 1 | Safety downgrade request |
| dg_ack | output | 1 | Downgrade drained acknowledgement |
| cnt_ld_fast | output | CNTW | Loads retired without waiting |
| cnt_ld_wait | output | CNTW | Loads retired after waiting |
| cnt_merge | output | CNTW | Safe stores merged |

## Verification
Load retirement, forwarding and the drain head are combinational, so they are due in the same cycle as the inputs that cause them. The bench changes inputs on the falling edge and samples 2 ns later, before the next rising edge, so that a load probe is never seen by the counters. A store shows up in the drain and forward outputs from the cycle after the edge that accepts it. A downgrade acknowledgement is due on the third falling edge after the drain is enabled with two entries buffered. Counter effects are read on the falling edge after the edge where the load retires.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
    typedef enum logic [1:0] {
        SB_RUN   = 2'd0,
        SB_FLUSH = 2'd1,
        SB_ACK   = 2'd2
    } sb_state_e;
endpackage

// File: rtl/sb_order_fifo.sv
module sb_order_fifo #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [AW-1:0]     push_addr,
    input  logic [DW-1:0]     push_data,
    input  logic [DW/8-1:0]   push_be,
    input  logic              pop,
    output logic [AW-1:0]     head_addr,
    output logic [DW-1:0]     head_data,
    output logic [DW/8-1:0]   head_be,
    output logic              empty,
    output logic              full,
    input  logic [AW-1:0]     look_addr,
    output logic [DW/8-1:0]   fwd_be,
    output logic [DW-1:0]     fwd_data
);
    localparam int BW = DW / 8;
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    logic [AW-1:0] a_q [DEPTH];
    logic [DW-1:0] d_q [DEPTH];
    logic [BW-1:0] b_q [DEPTH];
    logic [PW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q;

    assign empty     = (cnt_q == '0);
    assign full      = (cnt_q == CW'(DEPTH));
    assign head_addr = a_q[rd_q];
    assign head_data = d_q[rd_q];
    assign head_be   = b_q[rd_q];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                a_q[i] <= '0;
                d_q[i] <= '0;
                b_q[i] <= '0;
            end
        end else begin
            if (push) begin
                a_q[wr_q] <= push_addr;
                d_q[wr_q] <= push_data;
                b_q[wr_q] <= push_be;
                wr_q      <= wr_q + 1'b1;
            end
            if (pop) rd_q <= rd_q + 1'b1;
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    // Walk oldest to youngest so the youngest matching byte overwrites.
    always_comb begin
        logic [PW-1:0] idx;
        fwd_be   = '0;
        fwd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            idx = rd_q + PW'(i);
            if ((CW'(i) < cnt_q) && (a_q[idx] == look_addr)) begin
                for (int b = 0; b < BW; b++) begin
                    if (b_q[idx][b]) begin
                        fwd_be[b]          = 1'b1;
                        fwd_data[b*8 +: 8] = d_q[idx][b*8 +: 8];
                    end
                end
            end
        end
    end

    assert_fifo_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_fifo_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/sb_merge_buf.sv
module sb_merge_buf #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int SLOTS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [DW/8-1:0]   wr_be,
    output logic              merged,
    input  logic              pop,
    output logic [AW-1:0]     out_addr,
    output logic [DW-1:0]     out_data,
    output logic [DW/8-1:0]   out_be,
    output logic              empty,
    output logic              full,
    input  logic [AW-1:0]     look_addr,
    output logic [DW/8-1:0]   fwd_be,
    output logic [DW-1:0]     fwd_data
);
    localparam int BW = DW / 8;
    localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic [SLOTS-1:0] v_q, hit, look_hit;
    logic [AW-1:0]    a_q [SLOTS];
    logic [DW-1:0]    d_q [SLOTS];
    logic [BW-1:0]    b_q [SLOTS];
    logic [SW-1:0]    hit_sel, free_sel, out_sel;

    always_comb begin
        hit_sel  = '0;
        free_sel = '0;
        out_sel  = '0;
        fwd_be   = '0;
        fwd_data = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            hit[i]      = v_q[i] && (a_q[i] == wr_addr);
            look_hit[i] = v_q[i] && (a_q[i] == look_addr);
            if (hit[i])   hit_sel  = SW'(i);
            if (!v_q[i])  free_sel = SW'(i);
            if (v_q[i])   out_sel  = SW'(i);
            if (look_hit[i]) begin
                fwd_be   = b_q[i];
                for (int b = 0; b < BW; b++)
                    fwd_data[b*8 +: 8] = b_q[i][b] ? d_q[i][b*8 +: 8] : 8'h00;
            end
        end
    end

    assign merged   = wr && (hit != '0);
    assign empty    = (v_q == '0);
    assign full     = (v_q == '1);
    assign out_addr = a_q[out_sel];
    assign out_data = d_q[out_sel];
    assign out_be   = b_q[out_sel];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
            for (int i = 0; i < SLOTS; i++) begin
                a_q[i] <= '0;
                d_q[i] <= '0;
                b_q[i] <= '0;
            end
        end else if (wr && merged) begin
            for (int b = 0; b < BW; b++)
                if (wr_be[b]) d_q[hit_sel][b*8 +: 8] <= wr_data[b*8 +: 8];
            b_q[hit_sel] <= b_q[hit_sel] | wr_be;
        end else if (wr) begin
            v_q[free_sel] <= 1'b1;
            a_q[free_sel] <= wr_addr;
            d_q[free_sel] <= wr_data;
            b_q[free_sel] <= wr_be;
        end else if (pop) begin
            v_q[out_sel] <= 1'b0;
        end
    end

    assert_single_slot_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(look_hit));
    assert_no_pop_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !wr);
    assert_no_alloc_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !merged) |-> !full);
endmodule

// File: rtl/split_store_buffer.sv
module split_store_buffer
    import ssb_pkg::*;
#(
    parameter int AW     = 16,
    parameter int DW     = 32,
    parameter int FDEPTH = 4,
    parameter int SDEPTH = 4,
    parameter int CNTW   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic              st_known,
    input  logic              st_safe,
    input  logic [AW-1:0]     st_addr,
    input  logic [DW-1:0]     st_data,
    input  logic [DW/8-1:0]   st_be,
    output logic              st_accept,
    output logic              st_stall,
    input  logic              ld_valid,
    input  logic              ld_known,
    input  logic              ld_safe,
    input  logic [AW-1:0]     ld_addr,
    output logic              ld_retire,
    output logic [DW/8-1:0]   ld_fwd_be,
    output logic [DW-1:0]     ld_fwd_data,
    output logic              dr_valid,
    input  logic              dr_ready,
    output logic [AW-1:0]     dr_addr,
    output logic [DW-1:0]     dr_data,
    output logic [DW/8-1:0]   dr_be,
    input  logic              dg_req,
    output logic              dg_ack,
    output logic [CNTW-1:0]   cnt_ld_fast,
    output logic [CNTW-1:0]   cnt_ld_wait,
    output logic [CNTW-1:0]   cnt_merge
);
    localparam int BW = DW / 8;

    sb_state_e state_q, state_d;
    logic run;
    logic f_push, f_pop, f_empty, f_full;
    logic s_wr, s_pop, s_empty, s_full, s_merged;
    logic from_fifo, from_safe, blocked_q;
    logic [AW-1:0] f_addr, s_addr;
    logic [DW-1:0] f_data, s_data, f_fwd_d, s_fwd_d;
    logic [BW-1:0] f_be, s_be, f_fwd_b, s_fwd_b;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SB_RUN;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SB_RUN:   if (dg_req) state_d = SB_FLUSH;
            SB_FLUSH: if (f_empty && s_empty) state_d = SB_ACK;
            SB_ACK:   state_d = SB_RUN;
            default:  state_d = SB_RUN;
        endcase
    end

    // FSM outputs
    always_comb begin
        run    = 1'b0;
        dg_ack = 1'b0;
        unique case (state_q)
            SB_RUN:   run    = 1'b1;
            SB_FLUSH: run    = 1'b0;
            SB_ACK:   dg_ack = 1'b1;
            default:  run    = 1'b0;
        endcase
    end

    assign st_stall  = !run || f_full || s_full;
    assign st_accept = st_valid && st_known && !st_stall;
    assign f_push    = st_accept && !st_safe;
    assign s_wr      = st_accept && st_safe;

    assign from_fifo = !f_empty;
    assign from_safe = f_empty && !s_empty && !s_wr;
    assign dr_valid  = from_fifo || from_safe;
    assign dr_addr   = from_fifo ? f_addr : s_addr;
    assign dr_data   = from_fifo ? f_data : s_data;
    assign dr_be     = from_fifo ? f_be   : s_be;
    assign f_pop     = dr_ready && from_fifo;
    assign s_pop     = dr_ready && from_safe;

    assign ld_retire = ld_valid && ld_known && (ld_safe || f_empty);

    always_comb begin
        for (int b = 0; b < BW; b++) begin
            ld_fwd_be[b]          = f_fwd_b[b] || s_fwd_b[b];
            ld_fwd_data[b*8 +: 8] = f_fwd_b[b] ? f_fwd_d[b*8 +: 8] : s_fwd_d[b*8 +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blocked_q   <= 1'b0;
            cnt_ld_fast <= '0;
            cnt_ld_wait <= '0;
            cnt_merge   <= '0;
        end else begin
            if (ld_retire) begin
                blocked_q <= 1'b0;
                if (blocked_q) cnt_ld_wait <= cnt_ld_wait + 1'b1;
                else           cnt_ld_fast <= cnt_ld_fast + 1'b1;
            end else if (ld_valid) begin
                blocked_q <= 1'b1;
            end
            if (s_merged) cnt_merge <= cnt_merge + 1'b1;
        end
    end

    sb_order_fifo #(.AW(AW), .DW(DW), .DEPTH(FDEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(f_push), .push_addr(st_addr), .push_data(st_data), .push_be(st_be),
        .pop(f_pop), .head_addr(f_addr), .head_data(f_data), .head_be(f_be),
        .empty(f_empty), .full(f_full),
        .look_addr(ld_addr), .fwd_be(f_fwd_b), .fwd_data(f_fwd_d)
    );

    sb_merge_buf #(.AW(AW), .DW(DW), .SLOTS(SDEPTH)) u_safe (
        .clk(clk), .rst_n(rst_n),
        .wr(s_wr), .wr_addr(st_addr), .wr_data(st_data), .wr_be(st_be),
        .merged(s_merged),
        .pop(s_pop), .out_addr(s_addr), .out_data(s_data), .out_be(s_be),
        .empty(s_empty), .full(s_full),
        .look_addr(ld_addr), .fwd_be(s_fwd_b), .fwd_data(s_fwd_d)
    );

    assert_unsafe_load_waits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_retire && !ld_safe) |-> f_empty);
    assert_safe_after_fifo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        s_pop |-> f_empty);
    assert_ack_when_drained_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dg_ack |-> (f_empty && s_empty));
    assert_ack_single_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dg_ack |=> !dg_ack);
    assert_merge_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
        s_merged |=> (cnt_merge != $past(cnt_merge)));
endmodule

// File: tb/split_store_buffer_test.sv
`timescale 1ns/1ps
module split_store_buffer_test;
    localparam int AW = 16, DW = 32, BW = 4, CNTW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st_valid = 0, st_known = 0, st_safe = 0;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic [BW-1:0] st_be = '0;
    logic st_accept, st_stall;
    logic ld_valid = 0, ld_known = 0, ld_safe = 0;
    logic [AW-1:0] ld_addr = '0;
    logic ld_retire;
    logic [BW-1:0] ld_fwd_be;
    logic [DW-1:0] ld_fwd_data;
    logic dr_valid, dr_ready = 0;
    logic [AW-1:0] dr_addr;
    logic [DW-1:0] dr_data;
    logic [BW-1:0] dr_be;
    logic dg_req = 0, dg_ack;
    logic [CNTW-1:0] cnt_ld_fast, cnt_ld_wait, cnt_merge;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    split_store_buffer uut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_known(st_known), .st_safe(st_safe),
        .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
        .st_accept(st_accept), .st_stall(st_stall),
        .ld_valid(ld_valid), .ld_known(ld_known), .ld_safe(ld_safe), .ld_addr(ld_addr),
        .ld_retire(ld_retire), .ld_fwd_be(ld_fwd_be), .ld_fwd_data(ld_fwd_data),
        .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_addr(dr_addr),
        .dr_data(dr_data), .dr_be(dr_be),
        .dg_req(dg_req), .dg_ack(dg_ack),
        .cnt_ld_fast(cnt_ld_fast), .cnt_ld_wait(cnt_ld_wait), .cnt_merge(cnt_merge)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Present a store for one edge; check acceptance before the edge.
    task automatic store(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic [BW-1:0] be, input logic safe,
                         input logic known, input logic exp_acc, input string req);
        @(negedge clk);
        st_valid = 1; st_known = known; st_safe = safe;
        st_addr = a; st_data = d; st_be = be;
        #2 chk(req, "st_accept", st_accept, exp_acc);
        @(negedge clk);
        st_valid = 0; st_known = 0;
    endtask

    // Probe a load without letting it cross a clock edge.
    task automatic look(input logic [AW-1:0] a, input logic safe, input logic known,
                        input logic exp_ret, input logic [BW-1:0] exp_be,
                        input logic [DW-1:0] exp_d, input string req);
        @(negedge clk);
        ld_valid = 1; ld_safe = safe; ld_known = known; ld_addr = a;
        #2;
        chk(req, "ld_retire", ld_retire, exp_ret);
        chk(req, "ld_fwd_be", ld_fwd_be, exp_be);
        chk(req, "ld_fwd_data", ld_fwd_data, exp_d);
        ld_valid = 0; ld_known = 0;
    endtask

    task automatic drain(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic [BW-1:0] be, input string req);
        @(negedge clk);
        dr_ready = 1;
        #2;
        chk(req, "dr_valid", dr_valid, 1'b1);
        chk(req, "dr_addr", dr_addr, a);
        chk(req, "dr_data", dr_data, d);
        chk(req, "dr_be", dr_be, be);
        @(posedge clk);
        #1 dr_ready = 0;
    endtask

    task automatic expect_idle(input string req);
        @(negedge clk);
        #2 chk(req, "dr_valid idle", dr_valid, 1'b0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1", "dr_valid", dr_valid, 0);
        chk("R1", "dg_ack", dg_ack, 0);
        chk("R1", "st_stall", st_stall, 0);
        chk("R1", "cnt_ld_fast", cnt_ld_fast, 0);
        chk("R1", "cnt_ld_wait", cnt_ld_wait, 0);
        chk("R1", "cnt_merge", cnt_merge, 0);
    endtask

    task automatic t_unsafe_order;
        store(16'h0010, 32'h11111111, 4'hF, 0, 1, 1, "R2");
        store(16'h0010, 32'h22222222, 4'hF, 0, 1, 1, "R2");
        look(16'h0010, 0, 1, 0, 4'hF, 32'h22222222, "R8");
        look(16'h0020, 0, 1, 0, 4'h0, 32'h0, "R6");
        look(16'h0020, 1, 1, 1, 4'h0, 32'h0, "R5");
        drain(16'h0010, 32'h11111111, 4'hF, "R2");
        drain(16'h0010, 32'h22222222, 4'hF, "R2");
        expect_idle("R2");
        look(16'h0020, 0, 1, 1, 4'h0, 32'h0, "R6");
    endtask

    task automatic t_safe_merge;
        store(16'h0040, 32'hAABBCCDD, 4'hF, 1, 1, 1, "R3");
        store(16'h0040, 32'h00001100, 4'h2, 1, 1, 1, "R3");
        store(16'h0044, 32'h00000005, 4'hF, 1, 1, 1, "R3");
        store(16'h0080, 32'hDEADBEEF, 4'hF, 0, 1, 1, "R4");
        look(16'h0040, 0, 1, 0, 4'hF, 32'hAABB11DD, "R3");
        drain(16'h0080, 32'hDEADBEEF, 4'hF, "R4");
        look(16'h0044, 0, 1, 1, 4'hF, 32'h00000005, "R6");
        drain(16'h0040, 32'hAABB11DD, 4'hF, "R3");
        drain(16'h0044, 32'h00000005, 4'hF, "R4");
        expect_idle("R4");
        chk("R11", "cnt_merge", cnt_merge, 1);
    endtask

    task automatic t_partial_forward;
        store(16'h0050, 32'h11223344, 4'hF, 1, 1, 1, "R8");
        store(16'h0050, 32'h000000EE, 4'h1, 0, 1, 1, "R8");
        look(16'h0050, 1, 1, 1, 4'hF, 32'h112233EE, "R8");
        look(16'h0051, 1, 1, 1, 4'h0, 32'h0, "R8");
        drain(16'h0050, 32'h000000EE, 4'h1, "R4");
        drain(16'h0050, 32'h11223344, 4'hF, "R4");
        expect_idle("R4");
    endtask

    task automatic t_unknown;
        store(16'h0060, 32'h12345678, 4'hF, 0, 0, 0, "R7");
        store(16'h0061, 32'h12345678, 4'hF, 1, 0, 0, "R7");
        expect_idle("R7");
        look(16'h0060, 1, 0, 0, 4'h0, 32'h0, "R7");
    endtask

    task automatic t_full;
        for (int i = 0; i < 4; i++)
            store(16'h0100 + 16'(i), 32'hA0 + 32'(i), 4'hF, 0, 1, 1, "R9");
        chk("R9", "st_stall fifo full", st_stall, 1);
        store(16'h01FF, 32'h0, 4'hF, 1, 1, 0, "R9");
        for (int i = 0; i < 4; i++)
            drain(16'h0100 + 16'(i), 32'hA0 + 32'(i), 4'hF, "R9");
        expect_idle("R9");
        for (int i = 0; i < 4; i++)
            store(16'h0200 + 16'(i), 32'hB0 + 32'(i), 4'hF, 1, 1, 1, "R9");
        chk("R9", "st_stall safe full", st_stall, 1);
        store(16'h02FF, 32'h0, 4'hF, 0, 1, 0, "R9");
        for (int i = 0; i < 4; i++)
            drain(16'h0200 + 16'(i), 32'hB0 + 32'(i), 4'hF, "R4");
        expect_idle("R4");
    endtask

    task automatic t_downgrade;
        int n;
        store(16'h0300, 32'h33, 4'hF, 1, 1, 1, "R10");
        store(16'h0301, 32'h44, 4'hF, 0, 1, 1, "R10");
        @(negedge clk); dg_req = 1;
        @(negedge clk); dg_req = 0;
        #2;
        chk("R10", "dg_ack in flush", dg_ack, 0);
        chk("R10", "st_stall in flush", st_stall, 1);
        store(16'h0302, 32'h55, 4'hF, 1, 1, 0, "R10");
        @(negedge clk); dr_ready = 1;
        n = 0;
        for (int i = 1; i <= 10; i++) begin
            @(negedge clk);
            if (dg_ack && n == 0) n = i;
        end
        dr_ready = 0;
        chk("R10", "cycles to ack", n, 3);
        chk("R10", "dg_ack cleared", dg_ack, 0);
        chk("R10", "st_stall after", st_stall, 0);
        chk("R10", "drained", dr_valid, 0);
    endtask

    task automatic t_counters;
        store(16'h0400, 32'h77, 4'hF, 0, 1, 1, "R11");
        @(negedge clk); ld_valid = 1; ld_safe = 0; ld_known = 1; ld_addr = 16'h0400;
        @(negedge clk); dr_ready = 1;
        @(negedge clk); dr_ready = 0;
        #2 chk("R6", "unsafe load after drain", ld_retire, 1);
        @(negedge clk); ld_safe = 1; ld_addr = 16'h0500;
        @(negedge clk); ld_safe = 0;
        @(negedge clk); ld_valid = 0; ld_known = 0;
        chk("R11", "cnt_ld_fast", cnt_ld_fast, 2);
        chk("R11", "cnt_ld_wait", cnt_ld_wait, 1);
        chk("R11", "cnt_merge", cnt_merge, 1);
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_unsafe_order();
        t_safe_merge();
        t_partial_forward();
        t_unknown();
        t_full();
        t_downgrade();
        t_counters();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule